// File: doc/BRIEF.md
# Dual-Channel Protection Sequencer

This block is the digital supervisor for two buck regulator channels. Every analog decision reaches it as a comparator bit, already resolved upstream: supply above its power-on level, the enable/compensation pin above its disable level, and, per channel, feedback over-voltage, feedback under-voltage, the two power-good levels (rising and falling), over-current, and near-zero output. A shared over-temperature bit is the last input. From these the block runs each channel through a fixed order. First it samples the over-current threshold: a current source runs, a hold strobe captures the result, and the source then stops. Next comes a digital soft-start ramp whose code stands in for the reference. Normal regulation follows.

Faults are handled as follows:
- Under-voltage after soft-start opens a discharge path.
- Over-voltage holds the low-side switch on as a crowbar.
- Either of the two cases above latches both channels off once the output is near zero.
- Over-current or over-temperature latches both channels off at once.

The latch releases on loss of supply or when both enables are low together. The power-good output is open-drain. It is released only when both channels are regulating, neither is latched, and both feedbacks have passed a filtered, hysteretic good test.

Top module: `dual_prot_seq`

## Requirements
- R1: While reset is asserted or `por_ok` is low, every channel output (`hs_allow`, `ls_force`, `dchg_on`, `ocs_src`, `ocs_hold`, `ss_done`) is 0, `ss_code` is 0 and `pg_pull_low` is 1. `fault_latched` is 0 after reset.
- R2: A channel whose `en_hi` bit is 0 is off on the next cycle. When `en_hi` is 1, `por_ok` is 1 and no fault is latched, the channel leaves off and starts a new sequence.
- R3: Each start begins with exactly SAMPLE_CYC cycles of `ocs_src`=1. `ocs_hold` is 1 only in the last of those cycles, and `ocs_src` is 0 in the following cycle.
- R4: After sampling, `hs_allow` rises with the channel's `ss_code` field (bits [c*SS_W +: SS_W]) at 0. The code rises by 1 every SS_DIV cycles and never exceeds REF_CODE. One cycle after reaching REF_CODE the channel sets `ss_done`. The ramp lasts REF_CODE*SS_DIV+1 cycles.
- R5: `fb_uv` is ignored before `ss_done`. With `ss_done` set, `fb_uv` moves that channel to discharge (`dchg_on`=1, `hs_allow`=0) on the next cycle. When `out_low` is then seen, the fault latches.
- R6: `fb_ov` during ramp or regulation moves that channel to crowbar (`ls_force`=1, `hs_allow`=0) on the next cycle, while the other channel keeps running. When `out_low` is then seen, the fault latches.
- R7: `ot_trip`, or `oc_trip` on a switching channel, sets `fault_latched` on the next edge. On the edge after `fault_latched` is set, all switching, crowbar and discharge outputs on both channels are 0.
- R8: `fault_latched` stays set while either enable stays high. It clears on the edge after `por_ok` goes low, or on the edge after both `en_hi` bits are low.
- R9: A channel's feedback becomes good after `fb_pg_hi` has been 1 for PG_DLY consecutive cycles. It becomes not-good after `fb_pg_lo` has been 0 for PG_DLY consecutive cycles; shorter drops have no effect. `pg_pull_low` is 0 only when both channels are good, both have `ss_done`, and no fault is latched.
- R10: `pg_pull_low` is 1 whenever any channel is ramping and whenever a fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply above power-on level |
| en_hi | input | 2 | Per-channel enable pin above disable level |
| fb_ov | input | 2 | Feedback above over-voltage level |
| fb_uv | input | 2 | Feedback below under-voltage level |
| fb_pg_hi | input | 2 | Feedback above rising power-good level |
| fb_pg_lo | input | 2 | Feedback above falling power-good level |
| oc_trip | input | 2 | Over-current comparator |
| ot_trip | input | 1 | Over-temperature comparator |
| out_low | input | 2 | Output below near-zero level |
| hs_allow | output | 2 | Channel switching permitted |
| ls_force | output | 2 | Low-side crowbar on |
| dchg_on | output | 2 | Soft-stop discharge switch on |
| ocs_src | output | 2 | Over-current setting source on |
| ocs_hold | output | 2 | Over-current setting hold strobe |
| ss_code | output | 2*SS_W | Soft-start codes, channel c at [c*SS_W +: SS_W] |
| ss_done | output | 2 | Channel regulating (soft-start done) |
| fault_latched | output | 1 | Shared fault latch |
| pg_pull_low | output | 1 | Open-drain power-good pull-down |

## Verification
Directed start-ups measure how long the sample phase and the ramp last, which separates an off-by-one in either counter from a correct sequence. Under-voltage held through a whole ramp shows whether the post-soft-start gate exists. Power-good is driven through rising, falling and hysteresis-band patterns, plus random drops shorter than the filter window, which separates the two thresholds and the delay count. Randomly chosen faults, on a random channel after a random dwell, show which path each fault takes (crowbar, discharge or immediate latch). The same run confirms that one fault stops both channels and that only the correct clear condition releases them.

// File: rtl/dps_pkg.sv
package dps_pkg;
   localparam int NCH = 2;

   typedef enum logic [2:0] {
      CH_OFF,
      CH_SAMPLE,
      CH_RAMP,
      CH_RUN,
      CH_SOFTSTOP,
      CH_CROWBAR
   } ch_state_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/dps_chan.sv
module dps_chan
   import dps_pkg::*;
#(
   parameter int SAMPLE_CYC = 64,
   parameter int SS_DIV     = 250,
   parameter int REF_CODE   = 500,
   parameter int SS_W       = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            por_ok,
   input  logic            en,
   input  logic            latched,
   input  logic            ov,
   input  logic            uv,
   input  logic            oc,
   input  logic            out_low,
   output logic            sw_en,
   output logic            ls_on,
   output logic            dchg,
   output logic            src_on,
   output logic            hold,
   output logic [SS_W-1:0] code,
   output logic            done,
   output logic            trip
);
   localparam int CNT_MAX = imax(SAMPLE_CYC, SS_DIV);
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0]   SAMP_LAST = CW'(SAMPLE_CYC - 1);
   localparam logic [CW-1:0]   DIV_LAST  = CW'(SS_DIV - 1);
   localparam logic [SS_W-1:0] REF_C     = SS_W'(REF_CODE);

   ch_state_t       st, st_nx;
   logic [CW-1:0]   cnt;
   logic [SS_W-1:0] code_q;

   always_comb begin
      st_nx = st;
      if (!por_ok || !en || latched) begin
         st_nx = CH_OFF;
      end else begin
         unique case (st)
            CH_OFF:    st_nx = CH_SAMPLE;
            CH_SAMPLE: if (cnt == SAMP_LAST) st_nx = CH_RAMP;
            CH_RAMP: begin
               if (ov)                  st_nx = CH_CROWBAR;
               else if (code_q == REF_C) st_nx = CH_RUN;
            end
            CH_RUN: begin
               if (ov)      st_nx = CH_CROWBAR;
               else if (uv) st_nx = CH_SOFTSTOP;
            end
            default: st_nx = st;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= CH_OFF;
         cnt    <= '0;
         code_q <= '0;
      end else begin
         st <= st_nx;
         if (st_nx != st)
            cnt <= '0;
         else if (st == CH_SAMPLE)
            cnt <= cnt + CW'(1);
         else if (st == CH_RAMP)
            cnt <= (cnt == DIV_LAST) ? '0 : cnt + CW'(1);

         if (st_nx != CH_RAMP && st_nx != CH_RUN)
            code_q <= '0;
         else if (st == CH_RAMP && st_nx == CH_RAMP && cnt == DIV_LAST && code_q != REF_C)
            code_q <= code_q + SS_W'(1);
      end
   end

   assign sw_en  = (st == CH_RAMP) || (st == CH_RUN);
   assign ls_on  = (st == CH_CROWBAR);
   assign dchg   = (st == CH_SOFTSTOP);
   assign src_on = (st == CH_SAMPLE);
   assign hold   = (st == CH_SAMPLE) && (cnt == SAMP_LAST);
   assign done   = (st == CH_RUN);
   assign code   = code_q;
   assign trip   = (sw_en && oc) || ((ls_on || dchg) && out_low);
endmodule

// File: rtl/dps_latch.sv
module dps_latch
   import dps_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           por_ok,
   input  logic [NCH-1:0] en,
   input  logic [NCH-1:0] trip,
   input  logic           ot,
   output logic           latched
);
   logic set_req;
   assign set_req = (|trip) || ot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         latched <= 1'b0;
      else if (!por_ok)   latched <= 1'b0;
      else if (set_req)   latched <= 1'b1;
      else if (en == '0)  latched <= 1'b0;
   end
endmodule

// File: rtl/dps_pg_filt.sv
module dps_pg_filt #(
   parameter int PG_DLY = 1250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hi,
   input  logic lo,
   output logic good
);
   generate
      if (PG_DLY == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) good <= 1'b0;
            else        good <= good ? lo : hi;
         end
      end else begin : g_count
         localparam int PW = $clog2(PG_DLY + 1);
         localparam logic [PW-1:0] LAST = PW'(PG_DLY - 1);
         logic [PW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               good <= 1'b0;
               cnt  <= '0;
            end else if (!good) begin
               if (hi) begin
                  if (cnt == LAST) begin good <= 1'b1; cnt <= '0; end
                  else cnt <= cnt + PW'(1);
               end else cnt <= '0;
            end else begin
               if (!lo) begin
                  if (cnt == LAST) begin good <= 1'b0; cnt <= '0; end
                  else cnt <= cnt + PW'(1);
               end else cnt <= '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dual_prot_seq.sv
module dual_prot_seq
   import dps_pkg::*;
#(
   parameter int SAMPLE_CYC = 64,
   parameter int SS_DIV     = 250,
   parameter int REF_CODE   = 500,
   parameter int SS_W       = 9,
   parameter int PG_DLY     = 1250
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_ok,
   input  logic [1:0]        en_hi,
   input  logic [1:0]        fb_ov,
   input  logic [1:0]        fb_uv,
   input  logic [1:0]        fb_pg_hi,
   input  logic [1:0]        fb_pg_lo,
   input  logic [1:0]        oc_trip,
   input  logic              ot_trip,
   input  logic [1:0]        out_low,
   output logic [1:0]        hs_allow,
   output logic [1:0]        ls_force,
   output logic [1:0]        dchg_on,
   output logic [1:0]        ocs_src,
   output logic [1:0]        ocs_hold,
   output logic [2*SS_W-1:0] ss_code,
   output logic [1:0]        ss_done,
   output logic              fault_latched,
   output logic              pg_pull_low
);
   generate
      if (SAMPLE_CYC < 1)            begin : g_bad_samp $error("SAMPLE_CYC must be >= 1"); end
      if (SS_DIV < 1)                begin : g_bad_div  $error("SS_DIV must be >= 1"); end
      if (PG_DLY < 1)                begin : g_bad_pg   $error("PG_DLY must be >= 1"); end
      if (REF_CODE < 1 || REF_CODE >= (1 << SS_W))
                                     begin : g_bad_ref  $error("REF_CODE must fit in SS_W bits"); end
   endgenerate

   logic [NCH-1:0] trip;
   logic [NCH-1:0] good;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         dps_chan #(
            .SAMPLE_CYC (SAMPLE_CYC),
            .SS_DIV     (SS_DIV),
            .REF_CODE   (REF_CODE),
            .SS_W       (SS_W)
         ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .por_ok  (por_ok),
            .en      (en_hi[c]),
            .latched (fault_latched),
            .ov      (fb_ov[c]),
            .uv      (fb_uv[c]),
            .oc      (oc_trip[c]),
            .out_low (out_low[c]),
            .sw_en   (hs_allow[c]),
            .ls_on   (ls_force[c]),
            .dchg    (dchg_on[c]),
            .src_on  (ocs_src[c]),
            .hold    (ocs_hold[c]),
            .code    (ss_code[c*SS_W +: SS_W]),
            .done    (ss_done[c]),
            .trip    (trip[c])
         );

         dps_pg_filt #(.PG_DLY(PG_DLY)) u_pg (
            .clk   (clk),
            .rst_n (rst_n),
            .hi    (fb_pg_hi[c]),
            .lo    (fb_pg_lo[c]),
            .good  (good[c])
         );
      end
   endgenerate

   dps_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .por_ok  (por_ok),
      .en      (en_hi),
      .trip    (trip),
      .ot      (ot_trip),
      .latched (fault_latched)
   );

   assign pg_pull_low = !((&good) && (&ss_done) && !fault_latched);
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
   parameter int SS_W     = 9,
   parameter int REF_CODE = 500
) (
   input logic              clk,
   input logic              rst_n,
   input logic              por_ok,
   input logic [1:0]        en_hi,
   input logic [1:0]        fb_uv,
   input logic [1:0]        hs_allow,
   input logic [1:0]        ls_force,
   input logic [1:0]        dchg_on,
   input logic [1:0]        ocs_src,
   input logic [1:0]        ocs_hold,
   input logic [2*SS_W-1:0] ss_code,
   input logic [1:0]        ss_done,
   input logic              fault_latched,
   input logic              pg_pull_low
);
   generate
      for (genvar c = 0; c < 2; c++) begin : g_c
         AST_RAMP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            int'(ss_code[c*SS_W +: SS_W]) <= REF_CODE);  // R4
         AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (hs_allow[c] && !ss_done[c] && $past(hs_allow[c]))
            |-> (ss_code[c*SS_W +: SS_W] >= $past(ss_code[c*SS_W +: SS_W]) &&
                 int'(ss_code[c*SS_W +: SS_W]) <= int'($past(ss_code[c*SS_W +: SS_W])) + 1));  // R4
         AST_HOLD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
            ocs_hold[c] |=> !ocs_src[c]);  // R3
         AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !en_hi[c] |=> (!hs_allow[c] && !ocs_src[c]));  // R2
         AST_UV_IN_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
            (fb_uv[c] && hs_allow[c] && !ss_done[c]) |=> !dchg_on[c]);  // R5
      end
   endgenerate

   AST_LATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_latched && $past(fault_latched))
      |-> (hs_allow == 2'b00 && ls_force == 2'b00 && dchg_on == 2'b00));  // R7
   AST_PG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      fault_latched |-> pg_pull_low);  // R10
   AST_PG_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hs_allow & ~ss_done)) |-> pg_pull_low);  // R10
   AST_POR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !por_ok |=> !fault_latched);  // R8
endmodule

bind dual_prot_seq dps_checker #(.SS_W(SS_W), .REF_CODE(REF_CODE)) u_dps_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .por_ok        (por_ok),
   .en_hi         (en_hi),
   .fb_uv         (fb_uv),
   .hs_allow      (hs_allow),
   .ls_force      (ls_force),
   .dchg_on       (dchg_on),
   .ocs_src       (ocs_src),
   .ocs_hold      (ocs_hold),
   .ss_code       (ss_code),
   .ss_done       (ss_done),
   .fault_latched (fault_latched),
   .pg_pull_low   (pg_pull_low)
);

// File: tb/dual_prot_seq_bench.sv
`timescale 1ns/1ps
module dual_prot_seq_bench;
   localparam int SAMP = 3;
   localparam int DIV  = 2;
   localparam int REFC = 8;
   localparam int SW   = 9;
   localparam int PGD  = 4;

   logic clk = 1'b0;
   logic rst_n;
   logic por_ok;
   logic [1:0] en_hi, fb_ov, fb_uv, fb_pg_hi, fb_pg_lo, oc_trip, out_low;
   logic ot_trip;
   logic [1:0] hs_allow, ls_force, dchg_on, ocs_src, ocs_hold, ss_done;
   logic [2*SW-1:0] ss_code;
   logic fault_latched, pg_pull_low;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   dual_prot_seq #(
      .SAMPLE_CYC(SAMP), .SS_DIV(DIV), .REF_CODE(REFC), .SS_W(SW), .PG_DLY(PGD)
   ) u_dual_prot_seq (
      .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_hi(en_hi), .fb_ov(fb_ov),
      .fb_uv(fb_uv), .fb_pg_hi(fb_pg_hi), .fb_pg_lo(fb_pg_lo), .oc_trip(oc_trip),
      .ot_trip(ot_trip), .out_low(out_low), .hs_allow(hs_allow), .ls_force(ls_force),
      .dchg_on(dchg_on), .ocs_src(ocs_src), .ocs_hold(ocs_hold), .ss_code(ss_code),
      .ss_done(ss_done), .fault_latched(fault_latched), .pg_pull_low(pg_pull_low)
   );

   function automatic int ramp_len();
      return REFC * DIV + 1;
   endfunction

   // expected {ls_force, dchg_on} of the faulting channel one cycle after injection
   // kinds: 0 over-temperature, 1 over-current, 2 over-voltage, 3 under-voltage
   function automatic logic [1:0] exp_action(input int kind);
      case (kind)
         2:       return 2'b10;
         3:       return 2'b01;
         default: return 2'b00;
      endcase
   endfunction

   function automatic int code_of(input int c);
      return int'(ss_code[c*SW +: SW]);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bring_up();
      en_hi = 2'b11;
      for (int i = 0; i < 200; i++) begin
         if (ss_done == 2'b11) break;
         tick(1);
      end
      chk("R2 both channels regulating", int'(ss_done), 3);
   endtask

   task automatic clear_all();
      fb_ov = 0; fb_uv = 0; oc_trip = 0; ot_trip = 0; out_low = 0;
      en_hi = 2'b00;
      tick(1);
      chk("R8 latch cleared by both enables low", int'(fault_latched), 0);
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      int cnt, hold_at, rc, prev, bad, c, kind;
      logic [1:0] act;
      void'($urandom(32'd2024));
      rst_n = 0; por_ok = 0; en_hi = 0; fb_ov = 0; fb_uv = 0; oc_trip = 0;
      ot_trip = 0; out_low = 0; fb_pg_hi = 2'b11; fb_pg_lo = 2'b11;
      tick(2);
      // R1 reset state
      chk("R1 hs_allow in reset", int'(hs_allow), 0);
      chk("R1 pg in reset", int'(pg_pull_low), 1);
      chk("R1 latch in reset", int'(fault_latched), 0);
      chk("R1 ocs_src in reset", int'(ocs_src), 0);
      rst_n = 1; en_hi = 2'b11;
      tick(5);
      chk("R1 por low keeps off", int'({ocs_src, hs_allow, ss_done}), 0);
      chk("R1 pg with por low", int'(pg_pull_low), 1);

      // R3/R4: channel 0 alone
      por_ok = 1; en_hi = 2'b01;
      tick(1);
      cnt = 0; hold_at = 0;
      while (ocs_src[0] && cnt < 100) begin
         cnt++;
         if (ocs_hold[0]) hold_at = cnt;
         tick(1);
      end
      chk("R3 sample length", cnt, SAMP);
      chk("R3 hold in last sample cycle", hold_at, SAMP);
      chk("R4 ramp starts at zero", code_of(0), 0);
      chk("R4 switching starts after sample", int'(hs_allow[0]), 1);
      rc = 0; prev = 0; bad = 0;
      while (hs_allow[0] && !ss_done[0] && rc < 1000) begin
         if (code_of(0) < prev || code_of(0) > prev + 1) bad++;
         if (pg_pull_low != 1'b1) bad++;
         prev = code_of(0);
         rc++;
         tick(1);
      end
      chk("R4 ramp length", rc, ramp_len());
      chk("R4 ramp steps and R10 pg low in ramp", bad, 0);
      chk("R4 final code", code_of(0), REFC);
      chk("R2 disabled channel stays off", int'({hs_allow[1], ocs_src[1]}), 0);
      chk("R9 pg needs both channels", int'(pg_pull_low), 1);

      // R9 release and hysteresis
      bring_up();
      chk("R9 pg released", int'(pg_pull_low), 0);
      fb_pg_hi[0] = 0; tick(6);
      chk("R9 hysteresis band keeps good", int'(pg_pull_low), 0);
      fb_pg_lo[0] = 0; tick(PGD - 1);
      chk("R9 falling delay not yet", int'(pg_pull_low), 0);
      tick(1);
      chk("R9 falling delay elapsed", int'(pg_pull_low), 1);
      fb_pg_lo[0] = 1; tick(6);
      chk("R9 falling level alone does not restore", int'(pg_pull_low), 1);
      fb_pg_hi[0] = 1; tick(PGD - 1);
      chk("R9 rising delay not yet", int'(pg_pull_low), 1);
      tick(1);
      chk("R9 rising delay elapsed", int'(pg_pull_low), 0);
      for (int g = 0; g < 4; g++) begin
         fb_pg_lo[g % 2] = 0;
         tick($urandom_range(1, PGD - 1));
         fb_pg_lo[g % 2] = 1;
         tick(1);
         chk("R9 short drop filtered", int'(pg_pull_low), 0);
      end

      // R8 latch clear conditions
      ot_trip = 1; tick(2);
      chk("R7 over-temperature latches", int'(fault_latched), 1);
      chk("R7 all off after latch", int'({hs_allow, ls_force, dchg_on}), 0);
      chk("R10 pg low in latch", int'(pg_pull_low), 1);
      ot_trip = 0; en_hi = 2'b10; tick(3);
      chk("R8 one enable low keeps latch", int'(fault_latched), 1);
      chk("R8 still off", int'(hs_allow), 0);
      clear_all();
      en_hi = 2'b11; tick(2);
      chk("R2 restart after clear", int'(ocs_src), 3);
      bring_up();
      ot_trip = 1; tick(2);
      ot_trip = 0; por_ok = 0; tick(1);
      chk("R8 power cycle clears latch", int'(fault_latched), 0);
      por_ok = 1;
      clear_all();

      // R5 under-voltage ignored during ramp
      fb_uv = 2'b11; en_hi = 2'b11;
      bad = 0;
      for (int i = 0; i < 200; i++) begin
         if (dchg_on != 0) bad++;
         if (hs_allow == 2'b11 && code_of(0) >= REFC - 1 && code_of(1) >= REFC - 1) break;
         tick(1);
      end
      fb_uv = 0;
      chk("R5 under-voltage ignored before soft-start done", bad, 0);
      chk("R5 channels still ramping", int'(hs_allow), 3);
      bring_up();

      // random faults
      for (int it = 0; it < 10; it++) begin
         kind = $urandom_range(0, 3);
         c = $urandom_range(0, 1);
         tick($urandom_range(0, 5));
         case (kind)
            0: ot_trip = 1;
            1: oc_trip[c] = 1;
            2: fb_ov[c] = 1;
            default: fb_uv[c] = 1;
         endcase
         if (kind >= 2) begin
            tick(1);
            act = {ls_force[c], dchg_on[c]};
            chk(kind == 2 ? "R6 crowbar on" : "R5 discharge on", int'(act), int'(exp_action(kind)));
            chk(kind == 2 ? "R6 faulted channel not switching" : "R5 faulted channel not switching",
                int'(hs_allow[c]), 0);
            chk(kind == 2 ? "R6 other channel runs" : "R5 other channel runs",
                int'(hs_allow[1-c]), 1);
            tick(3);
            chk(kind == 2 ? "R6 held until near zero" : "R5 held until near zero",
                int'({ls_force[c], dchg_on[c]}), int'(exp_action(kind)));
            out_low[c] = 1;
         end
         tick(2);
         chk("R7 fault latched", int'(fault_latched), 1);
         chk("R7 both channels off", int'({hs_allow, ls_force, dchg_on}), 0);
         chk("R10 pg low in fault", int'(pg_pull_low), 1);
         clear_all();
         bring_up();
      end

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule